// File: doc/BRIEF.md
# Event Block Formatter

This block builds the output record of one trigger for a sixteen-channel digitizer module. It sends the record as a stream of 32-bit words, one word per clock, with four sideband marker bits. A pulse on `evt_start` latches the trigger type, the data type and the system event number. The block then emits these words in turn:

1. a main header;
2. for each input 0 to 15, in ascending order: an optional input header, that input's hit words and an optional input trailer;
3. a main trailer.

The main trailer holds a CRC16 taken over the record. It also holds one flag per input, set when the event count of that input disagrees with the system event number.

Upstream hit processors present the records of the current input over a valid/ready handshake. Each record is either a plain hit or a hit with timing. A beat with `hit_eoi` high closes the current input and carries no hit. Each input keeps its own event counter, which counts the pulses seen on that input's `in_hdr_seen` line. The enables for input headers and input trailers are static configuration inputs.

The control is a state machine with six states:
- IDLE: waits for a block to start.
- MAIN_HDR: emits the main header.
- IN_HDR: emits the current input's header if it is enabled. Otherwise the cycle passes with no output word.
- HITS: accepts hit beats.
- IN_TRL: emits the current input's trailer if trailers are enabled.
- MAIN_TRL: emits the main trailer.

The transitions are:
- IDLE→MAIN_HDR on `evt_start`.
- MAIN_HDR→IN_HDR, with the input index set to 0.
- IN_HDR→HITS.
- HITS→IN_TRL on an accepted end-of-input beat.
- IN_TRL→IN_HDR, with the index incremented, while inputs remain.
- IN_TRL→MAIN_TRL after input 15.
- MAIN_TRL→IDLE.

Top module: `evblk_formatter`

## Requirements
- R1: The main header is always emitted first. Its layout is: bit 31 = 0; bits 30-27 = trigger type; bit 26 = 0; bits 25-23 = data type; bits 22-8 = 0; bits 7-0 = system event number.
- R2: The input header of input k is emitted only when `cfg_ihdr_en[k]` is 1. Its layout is: bit 31 = 1; bit 30 = 0; bits 29-23 = that input's 7-bit event count; bits 22-20 = 0; bits 19-16 = k; bits 15-0 = 0.
- R3: A plain hit (`hit_timed`=0) becomes the word: bits 31-23 = 0; bits 22-20 = time block; bits 19-16 = input; bits 15-9 = strip position; bits 8-0 = pulse height. The output word appears on the cycle after the beat is accepted.
- R4: A timed hit (`hit_timed`=1) becomes the word: bit 31 = 1; bits 30-27 = quality code; bits 26-23 = hit time; bits 22-20 = time block; bits 19-16 = input; bits 15-9 = position; bits 8-0 = pulse height.
- R5: When `cfg_itrl_en` is 1, each input ends with a trailer word. Its layout is: bits 31-30 = 2'b11; bits 29-20 = 0; bits 19-16 = input; bits 15-8 = 0; bits 7-0 = number of hits of that input, modulo 256.
- R6: Words appear in this order: main header; then, for inputs 0 to 15 in ascending order, that input's header, hits and trailer; then the main trailer. The cycle after the main trailer carries no word.
- R7: Main trailer bits 31-16 hold a CRC16 over every word emitted before the trailer, main header included. The CRC uses polynomial 0x1021 and seed 0xFFFF, and takes each word from bit 31 down to bit 0.
- R8: Main trailer bit k (k = 0 to 15) is 1 exactly when the event count of input k differs from bits 6-0 of the system event number. Each input's count is the number of its `in_hdr_seen` pulses since reset, modulo 128.
- R9: `out_valid` (data enable) is 1 only on word cycles. `out_hdr` is 1 only on the main-header word. `out_trl` is 1 only on the main-trailer word. `out_half` is 1 exactly on the input header, hit and trailer words of inputs 8 to 15.
- R10: After reset, `out_valid`, `out_hdr`, `out_trl`, `out_half` and `hit_ready` are 0.
- R11: `hit_ready` is 1 only while hit beats are accepted. An `evt_start` pulse that arrives while a block is in progress is ignored: it adds no words, and no words follow the main trailer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ihdr_en | input | 16 | Per-input header enable |
| cfg_itrl_en | input | 1 | Input trailer enable |
| evt_start | input | 1 | Start of a block; the header fields are latched with it |
| evt_trig | input | 4 | Trigger type |
| evt_dtype | input | 3 | Data type |
| evt_sysnum | input | 8 | System event number |
| in_hdr_seen | input | 16 | One pulse per header arriving on each input |
| hit_valid | input | 1 | Hit beat valid |
| hit_eoi | input | 1 | Beat closes the current input and carries no hit |
| hit_timed | input | 1 | Selects the timed hit format |
| hit_quality | input | 4 | Quality code of a timed hit |
| hit_time | input | 4 | Hit time of a timed hit |
| hit_tblk | input | 3 | Time block index |
| hit_pos | input | 7 | Strip position |
| hit_height | input | 9 | Pulse height |
| hit_ready | output | 1 | A hit beat is accepted this cycle |
| out_data | output | 32 | Output word |
| out_valid | output | 1 | Data enable marker |
| out_hdr | output | 1 | Main header marker |
| out_trl | output | 1 | Main trailer marker |
| out_half | output | 1 | Word belongs to inputs 8 to 15 |

## Verification
A wrong input index or a stuck state shows at the ports on the very next word. It puts the wrong bits 19-16 in a hit word, moves an input header out of place, or brings the main trailer early or late, and the scoreboard sees this at once. A CRC register that was fed the wrong words, or was not seeded, corrupts only the main trailer, so the fault shows at the end of the block. A miscounted input event counter appears in two places: in bits 29-23 of that input's header, and as a spurious or missing flag in the trailer of the same block.

// File: rtl/blkfmt_pkg.sv
package blkfmt_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_MAIN_HDR,
        S_IN_HDR,
        S_HITS,
        S_IN_TRL,
        S_MAIN_TRL
    } fmt_state_t;

    // One word folded into the CRC, most significant bit first
    function automatic logic [15:0] crc_fold(input logic [15:0] c, input logic [31:0] w);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int b = 31; b >= 0; b--) begin
            fb = r[15] ^ w[b];
            r  = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        return r;
    endfunction

endpackage

// File: rtl/blkfmt_evcnt.sv
module blkfmt_evcnt #(
    parameter int N_IN = 16,
    parameter int CW   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   hdr_seen,
    input  logic [CW-1:0]     ref_num,
    output logic [N_IN*CW-1:0] cnt_flat,
    output logic [N_IN-1:0]   mism
);

    for (genvar k = 0; k < N_IN; k++) begin : g_ch
        logic [CW-1:0] cnt_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (hdr_seen[k])
                cnt_q <= cnt_q + 1'b1;
        end

        assign cnt_flat[k*CW +: CW] = cnt_q;
        assign mism[k] = (cnt_q != ref_num);
    end

endmodule

// File: rtl/blkfmt_crc.sv
module blkfmt_crc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        seed,
    input  logic        upd,
    input  logic [31:0] word,
    output logic [15:0] crc
);
    import blkfmt_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc <= 16'hFFFF;
        else if (seed)
            crc <= 16'hFFFF;
        else if (upd)
            crc <= crc_fold(crc, word);
    end

endmodule

// File: rtl/evblk_formatter.sv
module evblk_formatter #(
    parameter int N_IN  = 16,
    parameter int EVC_W = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cfg_ihdr_en,
    input  logic        cfg_itrl_en,
    input  logic        evt_start,
    input  logic [3:0]  evt_trig,
    input  logic [2:0]  evt_dtype,
    input  logic [7:0]  evt_sysnum,
    input  logic [15:0] in_hdr_seen,
    input  logic        hit_valid,
    input  logic        hit_eoi,
    input  logic        hit_timed,
    input  logic [3:0]  hit_quality,
    input  logic [3:0]  hit_time,
    input  logic [2:0]  hit_tblk,
    input  logic [6:0]  hit_pos,
    input  logic [8:0]  hit_height,
    output logic        hit_ready,
    output logic [31:0] out_data,
    output logic        out_valid,
    output logic        out_hdr,
    output logic        out_trl,
    output logic        out_half
);
    import blkfmt_pkg::*;

    localparam logic [3:0] LAST_IN = 4'(N_IN - 1);
    localparam logic [3:0] HALF_IN = 4'(N_IN / 2);

    fmt_state_t state, state_nx;

    logic [3:0]  idx;
    logic [7:0]  hcnt;
    logic [3:0]  trig_q;
    logic [2:0]  dtype_q;
    logic [7:0]  sys_q;

    logic        emit;
    logic [31:0] word;
    logic [15:0] crc;
    logic        crc_seed;

    logic [N_IN*EVC_W-1:0] evc_flat;
    logic [N_IN-1:0]       mism;
    logic [15:0]           err16;
    logic [EVC_W-1:0]      cur_cnt;

    blkfmt_evcnt #(.N_IN(N_IN), .CW(EVC_W)) evcnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hdr_seen (in_hdr_seen[N_IN-1:0]),
        .ref_num  (sys_q[EVC_W-1:0]),
        .cnt_flat (evc_flat),
        .mism     (mism)
    );

    assign crc_seed = (state == S_IDLE) && evt_start;

    blkfmt_crc crc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (crc_seed),
        .upd   (emit && (state != S_MAIN_TRL)),
        .word  (word),
        .crc   (crc)
    );

    always_comb begin
        err16 = '0;
        err16[N_IN-1:0] = mism;
        cur_cnt = evc_flat[int'(idx)*EVC_W +: EVC_W];
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    // Next state, word selection and handshake
    always_comb begin
        state_nx  = state;
        emit      = 1'b0;
        word      = '0;
        hit_ready = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (evt_start)
                    state_nx = S_MAIN_HDR;
            end
            S_MAIN_HDR: begin
                emit     = 1'b1;
                word     = {1'b0, trig_q, 1'b0, dtype_q, 15'd0, sys_q};
                state_nx = S_IN_HDR;
            end
            S_IN_HDR: begin
                emit     = cfg_ihdr_en[idx];
                word     = {2'b10, cur_cnt, 3'd0, idx, 16'd0};
                state_nx = S_HITS;
            end
            S_HITS: begin
                hit_ready = 1'b1;
                if (hit_valid && !hit_eoi) begin
                    emit = 1'b1;
                    word = hit_timed
                         ? {1'b1, hit_quality, hit_time, hit_tblk, idx, hit_pos, hit_height}
                         : {9'd0, hit_tblk, idx, hit_pos, hit_height};
                end
                if (hit_valid && hit_eoi)
                    state_nx = S_IN_TRL;
            end
            S_IN_TRL: begin
                emit     = cfg_itrl_en;
                word     = {2'b11, 10'd0, idx, 8'd0, hcnt};
                state_nx = (idx == LAST_IN) ? S_MAIN_TRL : S_IN_HDR;
            end
            S_MAIN_TRL: begin
                emit     = 1'b1;
                word     = {crc, err16};
                state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // Registered outputs and per-block context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            out_hdr   <= 1'b0;
            out_trl   <= 1'b0;
            out_half  <= 1'b0;
            idx       <= '0;
            hcnt      <= '0;
            trig_q    <= '0;
            dtype_q   <= '0;
            sys_q     <= '0;
        end else begin
            out_valid <= emit;
            out_data  <= emit ? word : 32'd0;
            out_hdr   <= (state == S_MAIN_HDR);
            out_trl   <= (state == S_MAIN_TRL);
            out_half  <= emit && (idx >= HALF_IN)
                         && (state inside {S_IN_HDR, S_HITS, S_IN_TRL});
            if (state == S_IDLE && evt_start) begin
                trig_q  <= evt_trig;
                dtype_q <= evt_dtype;
                sys_q   <= evt_sysnum;
            end
            if (state == S_MAIN_HDR)
                idx <= '0;
            else if (state == S_IN_TRL && idx != LAST_IN)
                idx <= idx + 1'b1;
            if (state == S_IN_HDR)
                hcnt <= '0;
            else if (state == S_HITS && hit_valid && !hit_eoi)
                hcnt <= hcnt + 1'b1;
        end
    end

    AST_MAIN_HDR_FMT: assert property (@(posedge clk) disable iff (!rst_n)
        out_hdr |-> (out_valid && !out_data[31])); // R1
    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && hit_ready && !hit_eoi) |=> (out_valid && !out_hdr && !out_trl)); // R3
    AST_TRL_IS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        out_trl |-> (out_valid && !out_hdr)); // R9
    AST_QUIET_AFTER_TRL: assert property (@(posedge clk) disable iff (!rst_n)
        out_trl |=> !out_valid); // R6
    AST_NO_READY_ON_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        out_hdr |-> !hit_ready); // R11

endmodule

// File: tb/evblk_formatter_tb_top.sv
module evblk_formatter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_ihdr_en = 16'hFFFF;
    logic        cfg_itrl_en = 1'b1;
    logic        evt_start = 1'b0;
    logic [3:0]  evt_trig = '0;
    logic [2:0]  evt_dtype = '0;
    logic [7:0]  evt_sysnum = '0;
    logic [15:0] in_hdr_seen = '0;
    logic        hit_valid = 1'b0;
    logic        hit_eoi = 1'b0;
    logic        hit_timed = 1'b0;
    logic [3:0]  hit_quality = '0;
    logic [3:0]  hit_time = '0;
    logic [2:0]  hit_tblk = '0;
    logic [6:0]  hit_pos = '0;
    logic [8:0]  hit_height = '0;
    logic        hit_ready;
    logic [31:0] out_data;
    logic        out_valid, out_hdr, out_trl, out_half;

    always #2.5 clk = ~clk;

    evblk_formatter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_ihdr_en(cfg_ihdr_en), .cfg_itrl_en(cfg_itrl_en),
        .evt_start(evt_start), .evt_trig(evt_trig), .evt_dtype(evt_dtype),
        .evt_sysnum(evt_sysnum), .in_hdr_seen(in_hdr_seen), .hit_valid(hit_valid),
        .hit_eoi(hit_eoi), .hit_timed(hit_timed), .hit_quality(hit_quality),
        .hit_time(hit_time), .hit_tblk(hit_tblk), .hit_pos(hit_pos),
        .hit_height(hit_height), .hit_ready(hit_ready), .out_data(out_data),
        .out_valid(out_valid), .out_hdr(out_hdr), .out_trl(out_trl), .out_half(out_half)
    );

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    // Scoreboard: {hdr, trl, half, data} plus the requirement it checks
    logic [34:0] exp_q[$];
    string       tag_q[$];

    int          hn[16];
    logic [27:0] hr[16][4];   // {timed, quality, time, tblk, pos, height}
    logic [6:0]  bcnt[16];

    function automatic logic [15:0] crc_w(input logic [15:0] c, input logic [31:0] w);
        logic [15:0] r = c;
        for (int b = 31; b >= 0; b--)
            r = {r[14:0], 1'b0} ^ ((r[15] ^ w[b]) ? 16'h1021 : 16'h0);
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [34:0] act, input logic [34:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic push_exp(input logic h, input logic t, input logic hf,
                            input logic [31:0] w, input string tag);
        exp_q.push_back({h, t, hf, w});
        tag_q.push_back(tag);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R6/R11 unexpected word", {out_hdr, out_trl, out_half, out_data}, '0);
                end else begin
                    logic [34:0] e;
                    string tg;
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    chk({out_hdr, out_trl, out_half, out_data} == e, tg,
                        {out_hdr, out_trl, out_half, out_data}, e);
                end
            end else if (out_hdr || out_trl || out_half) begin
                chk(0, "R9 marker without data enable", {out_hdr, out_trl, out_half, 32'd0}, '0);
            end
        end
    end

    task automatic pulse_hdr(input logic [15:0] m);
        @(negedge clk);
        in_hdr_seen = m;
        @(negedge clk);
        in_hdr_seen = '0;
        for (int i = 0; i < 16; i++)
            if (m[i]) bcnt[i] = bcnt[i] + 7'd1;
    endtask

    task automatic beat(input logic eoi, input logic [27:0] r, input logic inj);
        while (!hit_ready) @(negedge clk);
        hit_valid = 1'b1;
        hit_eoi = eoi;
        {hit_timed, hit_quality, hit_time, hit_tblk, hit_pos, hit_height} = r;
        evt_start = inj;
        @(negedge clk);
        hit_valid = 1'b0;
        hit_eoi = 1'b0;
        evt_start = 1'b0;
    endtask

    task automatic run_event(input logic [3:0] tr, input logic [2:0] dt,
                             input logic [7:0] sn, input int inject_in);
        logic [15:0] c;
        logic [31:0] w;
        logic [15:0] errs;
        c = 16'hFFFF;
        w = {1'b0, tr, 1'b0, dt, 15'd0, sn};
        push_exp(1, 0, 0, w, "R1 main header");
        c = crc_w(c, w);
        for (int i = 0; i < 16; i++) begin
            logic hf = (i >= 8);
            if (cfg_ihdr_en[i]) begin
                w = {2'b10, bcnt[i], 3'd0, 4'(i), 16'd0};
                push_exp(0, 0, hf, w, "R2 input header");
                c = crc_w(c, w);
            end
            for (int j = 0; j < hn[i]; j++) begin
                logic [27:0] r = hr[i][j];
                if (r[27]) begin
                    w = {1'b1, r[26:23], r[22:19], r[18:16], 4'(i), r[15:9], r[8:0]};
                    push_exp(0, 0, hf, w, "R4 timed hit");
                end else begin
                    w = {9'd0, r[18:16], 4'(i), r[15:9], r[8:0]};
                    push_exp(0, 0, hf, w, "R3 plain hit");
                end
                c = crc_w(c, w);
            end
            if (cfg_itrl_en) begin
                w = {2'b11, 10'd0, 4'(i), 8'd0, 8'(hn[i])};
                push_exp(0, 0, hf, w, "R5 input trailer");
                c = crc_w(c, w);
            end
        end
        for (int i = 0; i < 16; i++) errs[i] = (bcnt[i] != sn[6:0]);
        push_exp(0, 1, 0, {c, errs}, "R7/R8 main trailer crc and mismatch");

        @(negedge clk);
        evt_trig = tr; evt_dtype = dt; evt_sysnum = sn; evt_start = 1'b1;
        @(negedge clk);
        evt_start = 1'b0;
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < hn[i]; j++) beat(0, hr[i][j], (i == inject_in));
            beat(1, '0, 0);
        end
        for (int k = 0; k < 40 && exp_q.size() != 0; k++) @(negedge clk);
        chk(exp_q.size() == 0, "R6 block complete", 35'(exp_q.size()), '0);
        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0 && !hit_ready, "R11 idle after block", {34'd0, hit_ready}, '0);
    endtask

    task automatic clear_hits();
        for (int i = 0; i < 16; i++) hn[i] = 0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin hn[i] = 0; bcnt[i] = '0; end
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!out_valid && !out_hdr && !out_trl && !out_half && !hit_ready, "R10 reset state",
            {out_hdr, out_trl, out_half, 31'd0, out_valid}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Event 1: all headers and trailers, plain and timed hits
        pulse_hdr(16'hFFFF);
        clear_hits();
        hn[0] = 2;
        hr[0][0] = {1'b0, 4'd0, 4'd0, 3'd1, 7'd0, 9'h055};
        hr[0][1] = {1'b0, 4'd0, 4'd0, 3'd2, 7'd5, 9'h1FF};
        hn[9] = 1;
        hr[9][0] = {1'b1, 4'd3, 4'd9, 3'd4, 7'd64, 9'h100};
        run_event(4'hA, 3'd5, 8'd1, -1);

        // Event 2: upper input headers off, no trailers, one input out of step
        pulse_hdr(16'hFFFF);
        pulse_hdr(16'h0008);
        cfg_ihdr_en = 16'h00FF;
        cfg_itrl_en = 1'b0;
        clear_hits();
        hn[8] = 1;
        hr[8][0] = {1'b1, 4'd15, 4'd15, 3'd6, 7'd1, 9'd0};
        hn[15] = 1;
        hr[15][0] = {1'b0, 4'd0, 4'd0, 3'd6, 7'd127, 9'd511};
        run_event(4'h3, 3'd2, 8'd2, -1);

        // Event 3: system number above 127, stray start during hits
        pulse_hdr(16'hFFFF);
        cfg_ihdr_en = 16'hFFFF;
        cfg_itrl_en = 1'b1;
        clear_hits();
        hn[5] = 3;
        hr[5][0] = {1'b0, 4'd0, 4'd0, 3'd3, 7'd10, 9'd7};
        hr[5][1] = {1'b1, 4'd1, 4'd2, 3'd5, 7'd11, 9'd8};
        hr[5][2] = {1'b0, 4'd0, 4'd0, 3'd1, 7'd12, 9'd9};
        run_event(4'hF, 3'd7, 8'h83, 5);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule